// File: doc/BRIEF.md
# Programmable Rate-Generator Timer Channel

This block is one channel of an interval timer with a byte-wide host port. The host writes a command word to the control address and a 16-bit divisor, in two bytes, to the data address. Each enabled input tick moves the count one step down. When the count reaches one, the period output drops for that one step and the divisor is loaded again, so the output marks one pulse every divisor ticks. A gate input pauses the count without disturbing it.

The running count can be read at any time. A snapshot command copies the count into a hold register while counting goes on. The two following data reads return that copy, low byte first. When no snapshot is pending, reads return the live count with the same low-then-high byte order. A divisor of zero gives the longest period, 65536 ticks.

Top module: `rate_timer_chan`

## Requirements
- R1: After reset, period_out is 1, the counter is stopped, and the first data read returns the low byte of a count of 0.
- R2: A control write takes effect only when bits 7:6 of the byte equal parameter CHAN_IDX. Any other value in those bits changes nothing.
- R3: After a programming word, the first data write gives the low divisor byte and the second the high byte. The second write loads the count and starts the channel. The first decrement happens on the first enabled tick after that write.
- R4: While running, each cycle with tick=1 and gate=1 lowers the count by one. When the count is 1, that step reloads the divisor instead, so the period is the divisor in ticks (divisor at least 2).
- R5: period_out is 0 exactly while the channel runs with a count of 1, and 1 at all other times.
- R6: A divisor of 0 acts as 65536. The low pulses of period_out are then 65536 enabled ticks apart.
- R7: When gate=0 or tick=0, the count holds.
- R8: A control write with bits 5:0 all zero is a snapshot command. It copies the present count into a hold register, and counting goes on.
- R9: After a snapshot, two data reads return the held low byte and then the held high byte. Later reads return the live count.
- R10: A snapshot command given while a held value is still unread is ignored.
- R11: With nothing held, data reads return the live count, alternating low byte and high byte and starting with the low byte.
- R12: A control write that is not a snapshot (bits 5:0 nonzero) stops the counter, discards any held value, and resets both byte orders to low. The counter stays stopped until a new divisor is fully written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Count-enable tick |
| cs | input | 1 | Chip select |
| addr | input | 1 | 1 = control, 0 = data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; advances the read byte order |
| wdata | input | 8 | Write data |
| gate | input | 1 | Counting allowed while high |
| rdata | output | 8 | Read data, valid while rd is high |
| period_out | output | 1 | Normally high, low for one count step per period |

## Verification
The assertions check on every cycle that the count steps down by one on each enabled tick, that it holds when gate is low, that a held snapshot does not change until it has been read out, that every data read flips the read byte order, and that a low output always comes with a count of one. Only the bench's scenarios can show the end-to-end behaviour. These include the byte order of the divisor load, the exact period for small divisors and for the zero divisor, how a channel field that does not match is ignored, and how a second snapshot is dropped. They also include the stop caused by a programming word, compared against a cycle model during random bus traffic.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic              wr_hi;
        logic              rd_hi;
        logic              held;
        logic [CNT_W-1:0]  snap;
    } host_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             out;
    } core_st_t;
endpackage

// File: rtl/rtmr_hostif.sv
`timescale 1ns/1ps
module rtmr_hostif
    import rtmr_pkg::*;
#(
    parameter int CHAN_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  div_o,
    output logic              stop_o,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CHAN_IDX);

    host_st_t st_d, st_q;
    logic ctl_wr, dat_wr, dat_rd, sel_ok, snap_cmd, prog_cmd;
    logic [CNT_W-1:0] src;

    always_comb begin
        ctl_wr   = cs && wr && addr;
        dat_wr   = cs && wr && !addr;
        dat_rd   = cs && rd && !addr;
        sel_ok   = (wdata[BYTE_W-1 -: SEL_W] == MY_SEL);
        snap_cmd = ctl_wr && sel_ok && (wdata[BYTE_W-SEL_W-1:0] == '0);
        prog_cmd = ctl_wr && sel_ok && (wdata[BYTE_W-SEL_W-1:0] != '0);

        st_d = st_q;
        if (prog_cmd) begin
            st_d.wr_hi = 1'b0;
            st_d.rd_hi = 1'b0;
            st_d.held  = 1'b0;
        end else if (snap_cmd && !st_q.held) begin
            st_d.held  = 1'b1;
            st_d.snap  = count_i;
            st_d.rd_hi = 1'b0;
        end
        if (dat_wr) begin
            if (!st_q.wr_hi) begin
                st_d.lo    = wdata;
                st_d.wr_hi = 1'b1;
            end else begin
                st_d.wr_hi = 1'b0;
            end
        end
        if (dat_rd) begin
            st_d.rd_hi = !st_q.rd_hi;
            if (st_q.rd_hi && st_q.held) st_d.held = 1'b0;
        end

        load_o  = dat_wr && st_q.wr_hi;
        div_o   = {wdata, st_q.lo};
        stop_o  = prog_cmd;
        src     = st_q.held ? st_q.snap : count_i;
        rdata_o = st_q.rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held && !prog_cmd && !(dat_rd && st_q.rd_hi)) |=> (st_q.held && $stable(st_q.snap)));

    // R11
    rd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !ctl_wr) |=> (st_q.rd_hi != $past(st_q.rd_hi)));
endmodule

// File: rtl/rtmr_core.sv
`timescale 1ns/1ps
module rtmr_core
    import rtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    core_st_t st_d, st_q;
    logic adv;

    always_comb begin
        adv  = st_q.run && tick && gate;
        st_d = st_q;
        if (stop_i) begin
            st_d.run = 1'b0;
        end else if (load_i) begin
            st_d.cnt    = div_i;
            st_d.reload = div_i;
            st_d.run    = 1'b1;
        end else if (adv) begin
            if (st_q.cnt == CNT_W'(1)) st_d.cnt = st_q.reload;
            else                       st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.out = !(st_d.run && (st_d.cnt == CNT_W'(1)));
        count_o  = st_q.cnt;
        out_o    = st_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load_i && !stop_i && st_q.cnt != CNT_W'(1))
        |=> (st_q.cnt == CNT_W'($past(st_q.cnt) - 1'b1)));

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gate || !tick) && !load_i) |=> $stable(st_q.cnt));

    // R5
    out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_o |-> (st_q.run && st_q.cnt == CNT_W'(1)));

    // R12
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!st_q.run && out_o));
endmodule

// File: rtl/rate_timer_chan.sv
`timescale 1ns/1ps
module rate_timer_chan
    import rtmr_pkg::*;
#(
    parameter int CHAN_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cs,
    input  logic              addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              gate,
    output logic [BYTE_W-1:0] rdata,
    output logic              period_out
);
    logic             load_w, stop_w;
    logic [CNT_W-1:0] div_w, count_w;

    rtmr_hostif #(.CHAN_IDX(CHAN_IDX)) u_host (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
        .wdata(wdata), .count_i(count_w), .load_o(load_w), .div_o(div_w),
        .stop_o(stop_w), .rdata_o(rdata)
    );

    rtmr_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load_i(load_w),
        .div_i(div_w), .stop_i(stop_w), .count_o(count_w), .out_o(period_out)
    );
endmodule

// File: tb/tb_rate_timer_chan.sv
`timescale 1ns/1ps
module tb_rate_timer_chan;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 1'b0, cs = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0, gate = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic period_out;
    int n_chk = 0, n_fail = 0;
    longint cyc = 0;

    // model state
    logic [15:0] m_cnt = 0, m_rel = 0, m_snap = 0;
    logic [7:0]  m_lo = 0;
    logic m_run = 0, m_wrhi = 0, m_rdhi = 0, m_held = 0;

    always #2 clk = ~clk;

    rate_timer_chan #(.CHAN_IDX(0)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .addr(addr), .wr(wr),
        .rd(rd), .wdata(wdata), .gate(gate), .rdata(rdata), .period_out(period_out)
    );

    function automatic logic [7:0] exp_rd();
        logic [15:0] s;
        s = m_held ? m_snap : m_cnt;
        return m_rdhi ? s[15:8] : s[7:0];
    endfunction

    function automatic logic exp_out();
        return !(m_run && m_cnt == 16'd1);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_edge();
        logic cw, dw, dr, ok, snapc, progc, ld, adv;
        logic [15:0] cnt_pre;
        cnt_pre = m_cnt;
        cw = cs && wr && addr; dw = cs && wr && !addr; dr = cs && rd && !addr;
        ok = (wdata[7:6] == 2'd0);
        snapc = cw && ok && wdata[5:0] == 0;
        progc = cw && ok && wdata[5:0] != 0;
        ld = dw && m_wrhi;
        adv = m_run && tick && gate;
        if (progc) m_run = 0;
        else if (ld) begin m_cnt = {wdata, m_lo}; m_rel = {wdata, m_lo}; m_run = 1; end
        else if (adv) m_cnt = (m_cnt == 1) ? m_rel : m_cnt - 1;
        if (progc) begin m_wrhi = 0; m_rdhi = 0; m_held = 0; end
        else if (snapc && !m_held) begin m_held = 1; m_snap = cnt_pre; m_rdhi = 0; end
        if (dw) begin
            if (!m_wrhi) begin m_lo = wdata; m_wrhi = 1; end else m_wrhi = 0;
        end
        if (dr) begin
            if (m_rdhi && m_held) m_held = 0;
            m_rdhi = !m_rdhi;
        end
    endtask

    // one bus cycle: drive, check outputs, clock the model
    task automatic step(input logic i_cs, input logic i_addr, input logic i_wr,
                        input logic i_rd, input logic [7:0] i_wd, input logic i_tick,
                        input logic i_gate, input string tag);
        cs = i_cs; addr = i_addr; wr = i_wr; rd = i_rd; wdata = i_wd;
        tick = i_tick; gate = i_gate;
        #1;
        if (i_cs && i_rd && !i_addr)
            check(rdata === exp_rd(), {tag, " rdata"}, rdata, exp_rd());
        check(period_out === exp_out(), {tag, " period_out"}, period_out, exp_out());
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input int n, input logic t, input logic g, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, t, g, tag);
    endtask

    task automatic ctl(input logic [7:0] b, input string tag);
        step(1, 1, 1, 0, b, 0, 1, tag);
    endtask

    task automatic dwr(input logic [7:0] b, input string tag);
        step(1, 0, 1, 0, b, 0, 1, tag);
    endtask

    task automatic drd(input logic t, input string tag);
        step(1, 0, 0, 1, 8'h00, t, 1, tag);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint last_low, gap;
        int first;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(period_out === 1'b1, "R1 period_out after reset", period_out, 1);
        drd(0, "R1 live low byte after reset");
        drd(0, "R1 live high byte after reset");
        idle(4, 1, 1, "R1 stopped counter");

        // R3 program divisor 5, R4/R5 period
        ctl(8'h34, "R3 program word");
        dwr(8'h05, "R3 low byte");
        dwr(8'h00, "R3 high byte");
        check(dut.period_out === 1'b1 && m_cnt == 5, "R3 loaded count", m_cnt, 5);
        idle(17, 1, 1, "R4 R5 divisor 5 run");
        // R2 mismatched channel fields are ignored
        ctl(8'h74, "R2 wrong channel program");
        ctl(8'hC0, "R2 wrong channel snapshot");
        idle(6, 1, 1, "R2 still running");
        // R7 gate and tick low hold
        idle(5, 1, 0, "R7 gate low");
        idle(5, 0, 1, "R7 tick low");
        drd(0, "R11 live low");
        drd(0, "R11 live high");

        // R8 R9 R10 snapshot
        ctl(8'h34, "R12 reprogram");
        dwr(8'h34, "R3 low byte");
        dwr(8'h12, "R3 high byte");
        idle(3, 1, 1, "R4 count 0x1234");
        ctl(8'h00, "R8 snapshot");
        idle(7, 1, 1, "R8 counting continues");
        ctl(8'h00, "R10 second snapshot ignored");
        idle(2, 1, 1, "R8 counting continues");
        drd(1, "R9 held low byte");
        drd(1, "R9 held high byte");
        drd(1, "R9 R11 live low after snapshot");
        drd(1, "R9 R11 live high after snapshot");

        // R12 stop, held value dropped
        ctl(8'h00, "R8 snapshot");
        drd(0, "R9 held low byte");
        ctl(8'h34, "R12 program stops");
        idle(6, 1, 1, "R12 stopped");
        drd(0, "R12 low byte after stop");
        drd(0, "R12 high byte after stop");
        check(m_run == 0, "R12 model stopped", m_run, 0);

        // R6 zero divisor
        dwr(8'h00, "R6 low byte");
        dwr(8'h00, "R6 high byte");
        first = 1; last_low = 0;
        for (int i = 0; i < 65536 * 2 + 10; i++) begin
            step(0, 0, 0, 0, 8'h00, 1, 1, "R6 zero divisor run");
            if (period_out === 1'b0) begin
                if (!first) begin
                    gap = cyc - last_low;
                    check(gap == 65536, "R6 pulse spacing", gap, 65536);
                end
                first = 0; last_low = cyc;
            end
        end
        check(!first, "R6 pulse seen", first, 0);

        // random traffic
        ctl(8'h34, "R12 reprogram");
        dwr(8'h07, "R3 low byte");
        dwr(8'h00, "R3 high byte");
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic t, g;
            op = int'($urandom % 24);
            t = ($urandom % 4) != 0;
            g = ($urandom % 8) != 0;
            case (op)
                0:       step(1, 1, 1, 0, 8'h34, t, g, "R12 random program");
                1, 2:    step(1, 1, 1, 0, 8'h00, t, g, "R8 R10 random snapshot");
                3:       step(1, 1, 1, 0, {2'($urandom % 3 + 1), 6'($urandom)}, t, g, "R2 random other channel");
                4, 5:    step(1, 0, 1, 0, m_wrhi ? 8'($urandom % 2) : 8'($urandom % 40 + 2), t, g, "R3 random data");
                6, 7, 8: step(1, 0, 0, 1, 8'h00, t, g, "R9 R11 random read");
                default: step(0, 0, 0, 0, 8'h00, t, g, "R4 R5 R7 random idle");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule